// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the programmable state of a small set of hardware debug triggers. Software reaches it through four register codes: a select register that picks one trigger, a control register for the chosen trigger's fields, a value register for its match operand, and an auxiliary register that is always zero. Reads are combinational on a separate read address, and writes take effect at the clock edge.

The bank packs the stored fields into one XLEN-wide word on reads and unpacks that word on writes. A trigger whose debug-owned flag is set refuses all writes unless the hart is in debug mode. Arming a trigger for instruction fetch forces its timing bit to zero. The bank reduces the arming bits of all triggers to three check flags for the fetch, load and store paths. Each accepted control write sends a one-cycle flush request to the address-translation cache. Address comparison and firing happen elsewhere. The access port is plain register access with no back-pressure: every write is taken in the cycle it is presented.

Top module: `trig_bank`

## Requirements
- R1: A write to the select register (code 0) is taken only when the written value is below NTRIG. Otherwise the select register keeps its old value.
- R2: Writes to the control (code 1) or value (code 2) register are ignored while the selected trigger's debug-owned bit is 1 and `dbg_active` is 0. They are accepted when `dbg_active` is 1 or the bit is 0.
- R3: When a control write sets the execute bit (bit 2), the stored timing bit (bit 18) becomes 0. Without execute, the timing bit is stored as written.
- R4: The kind field, bits XLEN-1..XLEN-4 of a control read, always reads 2. A read of the auxiliary register (code 3) always returns 0.
- R5: `chk_fetch`, `chk_load` and `chk_store` are the OR over all triggers of the execute (bit 2), load (bit 0) and store (bit 1) bits. They are valid from the cycle after the write.
- R6: `xlate_flush` is high for the one cycle after each accepted control write. It stays low after a refused write or after a write to any other register.
- R7: After reset the select register is 0, every control read returns only the kind field (0x2000_0000 for XLEN=32), every value reads 0, and all check flags and the flush output are 0.
- R8: Control field layout: load 0, store 1, execute 2, U 3, S 4, H 5, M 6, match 10..7, chain 11, action 17..12, timing 18, select 19. The mask-width field XLEN-6..XLEN-11 and all other unlisted bits read 0.
- R9: The debug-owned bit sits at XLEN-5 and reads back as written.
- R10: Control and value writes change only the trigger named by the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_active | input | 1 | Hart is in debug mode |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register code for the write (0 select, 1 control, 2 value, 3 aux) |
| wr_data | input | XLEN | Write data |
| rd_addr | input | 2 | Register code for the read |
| rd_data | output | XLEN | Read data, combinational |
| chk_fetch | output | 1 | Some trigger is armed on fetch |
| chk_load | output | 1 | Some trigger is armed on load |
| chk_store | output | 1 | Some trigger is armed on store |
| xlate_flush | output | 1 | One-cycle translation cache flush request |

## Verification
The bench builds the bank with XLEN=32 and NTRIG=3. Because three triggers do not fill the two-bit select range, the code 3 is a real out-of-range select value next to the large values. With XLEN=32 the kind field, the debug-owned bit and the zero-reading mask field all sit at fixed, known positions. Three triggers are also enough to show the check flags gathering bits from different triggers and one trigger changing without disturbing the others.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    REG_SEL = 2'd0,
    REG_CTL = 2'd1,
    REG_VAL = 2'd2,
    REG_AUX = 2'd3
  } reg_id_e;

  localparam logic [3:0] KIND_VALUE = 4'd2;

  localparam int B_LD     = 0;
  localparam int B_ST     = 1;
  localparam int B_EX     = 2;
  localparam int B_U      = 3;
  localparam int B_S      = 4;
  localparam int B_H      = 5;
  localparam int B_M      = 6;
  localparam int B_MATCH  = 7;
  localparam int W_MATCH  = 4;
  localparam int B_CHAIN  = 11;
  localparam int B_ACTION = 12;
  localparam int W_ACTION = 6;
  localparam int B_TIMING = 18;
  localparam int B_SELECT = 19;

  typedef struct packed {
    logic                dmode;
    logic                select;
    logic                timing;
    logic [W_ACTION-1:0] action;
    logic                chain;
    logic [W_MATCH-1:0]  match;
    logic                m;
    logic                h;
    logic                s;
    logic                u;
    logic                ex;
    logic                st;
    logic                ld;
  } trig_ctl_t;

endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_active,
  input  logic            ctl_we,
  input  logic            val_we,
  input  logic [XLEN-1:0] wdata,
  output trig_ctl_t       ctl_q,
  output logic            locked,
  output logic [XLEN-1:0] rd_ctl,
  output logic [XLEN-1:0] rd_val
);

  localparam int B_DMODE = XLEN - 5;
  localparam int B_KIND  = XLEN - 4;

  logic [XLEN-1:0] val_q;
  trig_ctl_t       ctl_d;

  assign locked = ctl_q.dmode && !dbg_active;

  always_comb begin
    ctl_d.dmode  = wdata[B_DMODE];
    ctl_d.select = wdata[B_SELECT];
    ctl_d.timing = wdata[B_TIMING] & ~wdata[B_EX];
    ctl_d.action = wdata[B_ACTION +: W_ACTION];
    ctl_d.chain  = wdata[B_CHAIN];
    ctl_d.match  = wdata[B_MATCH +: W_MATCH];
    ctl_d.m      = wdata[B_M];
    ctl_d.h      = wdata[B_H];
    ctl_d.s      = wdata[B_S];
    ctl_d.u      = wdata[B_U];
    ctl_d.ex     = wdata[B_EX];
    ctl_d.st     = wdata[B_ST];
    ctl_d.ld     = wdata[B_LD];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      val_q <= '0;
    end else begin
      if (ctl_we && !locked) ctl_q <= ctl_d;
      if (val_we && !locked) val_q <= wdata;
    end
  end

  always_comb begin
    rd_ctl                        = '0;
    rd_ctl[B_KIND +: 4]           = KIND_VALUE;
    rd_ctl[B_DMODE]               = ctl_q.dmode;
    rd_ctl[B_SELECT]              = ctl_q.select;
    rd_ctl[B_TIMING]              = ctl_q.timing;
    rd_ctl[B_ACTION +: W_ACTION]  = ctl_q.action;
    rd_ctl[B_CHAIN]               = ctl_q.chain;
    rd_ctl[B_MATCH +: W_MATCH]    = ctl_q.match;
    rd_ctl[B_M]                   = ctl_q.m;
    rd_ctl[B_H]                   = ctl_q.h;
    rd_ctl[B_S]                   = ctl_q.s;
    rd_ctl[B_U]                   = ctl_q.u;
    rd_ctl[B_EX]                  = ctl_q.ex;
    rd_ctl[B_ST]                  = ctl_q.st;
    rd_ctl[B_LD]                  = ctl_q.ld;
  end

  assign rd_val = val_q;

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_we || val_we) && ctl_q.dmode && !dbg_active)
      |=> ($stable(ctl_q) && $stable(val_q)));

  assert_exec_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_q.dmode && wdata[B_EX]) |=> !ctl_q.timing);

endmodule

// File: rtl/trig_summary.sv
module trig_summary
  import trig_pkg::*;
#(
  parameter int NTRIG = 4
) (
  input  trig_ctl_t ctl [NTRIG],
  output logic      any_ex,
  output logic      any_ld,
  output logic      any_st
);

  always_comb begin
    any_ex = 1'b0;
    any_ld = 1'b0;
    any_st = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      any_ex = any_ex | ctl[i].ex;
      any_ld = any_ld | ctl[i].ld;
      any_st = any_st | ctl[i].st;
    end
  end

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NTRIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_active,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            chk_fetch,
  output logic            chk_load,
  output logic            chk_store,
  output logic            xlate_flush
);

  localparam int SELW = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam logic [XLEN-1:0] NTRIG_X = XLEN'(NTRIG);

  logic [SELW-1:0] sel_q;
  logic            sel_ok;
  logic            sel_take;
  logic            flush_q;
  logic            cur_locked;

  trig_ctl_t       ctl_a    [NTRIG];
  logic            locked_a [NTRIG];
  logic [XLEN-1:0] rctl_a   [NTRIG];
  logic [XLEN-1:0] rval_a   [NTRIG];

  assign sel_ok   = (32'(sel_q) < NTRIG);
  assign sel_take = wr_en && (wr_addr == REG_SEL) && (wr_data < NTRIG_X);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_take) sel_q <= wr_data[SELW-1:0];
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_slot
    logic hit;
    assign hit = sel_ok && (32'(sel_q) == g);
    trig_slot #(.XLEN(XLEN)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbg_active(dbg_active),
      .ctl_we    (wr_en && hit && (wr_addr == REG_CTL)),
      .val_we    (wr_en && hit && (wr_addr == REG_VAL)),
      .wdata     (wr_data),
      .ctl_q     (ctl_a[g]),
      .locked    (locked_a[g]),
      .rd_ctl    (rctl_a[g]),
      .rd_val    (rval_a[g])
    );
  end

  assign cur_locked = sel_ok ? locked_a[sel_q] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= wr_en && (wr_addr == REG_CTL) && !cur_locked;
  end
  assign xlate_flush = flush_q;

  trig_summary #(.NTRIG(NTRIG)) u_sum (
    .ctl   (ctl_a),
    .any_ex(chk_fetch),
    .any_ld(chk_load),
    .any_st(chk_store)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      REG_SEL: rd_data = XLEN'(sel_q);
      REG_CTL: if (sel_ok) rd_data = rctl_a[sel_q];
      REG_VAL: if (sel_ok) rd_data = rval_a[sel_q];
      REG_AUX: rd_data = '0;
      default: rd_data = '0;
    endcase
  end

  assert_sel_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok);

  assert_sel_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == REG_SEL) && (wr_data >= NTRIG_X)) |=> $stable(sel_q));

  assert_no_flush_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == REG_CTL) && cur_locked) |=> !xlate_flush);

  assert_aux_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == REG_AUX) |-> (rd_data == '0));

endmodule

// File: tb/trig_bank_tb.sv
`timescale 1ns/1ps
module trig_bank_tb;

  localparam int XLEN  = 32;
  localparam int NTRIG = 3;
  localparam int NV    = 26;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dbg_active = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = 2'd0;
  logic [XLEN-1:0] wr_data = '0;
  logic [1:0]      rd_addr = 2'd0;
  logic [XLEN-1:0] rd_data;
  logic            chk_fetch, chk_load, chk_store, xlate_flush;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  trig_bank #(.XLEN(XLEN), .NTRIG(NTRIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_active(dbg_active),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .chk_fetch(chk_fetch), .chk_load(chk_load), .chk_store(chk_store),
    .xlate_flush(xlate_flush)
  );

  // vector: {is_write, addr[1:0], dbg, data_or_expected[31:0]}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 2'd1, 1'b0, 32'h2000_0000},
    {1'b0, 2'd3, 1'b0, 32'h0000_0000},
    {1'b1, 2'd1, 1'b0, 32'h0004_0045},
    {1'b0, 2'd1, 1'b0, 32'h2000_0045},
    {1'b1, 2'd0, 1'b0, 32'h0000_0001},
    {1'b1, 2'd1, 1'b0, 32'h0004_0002},
    {1'b0, 2'd1, 1'b0, 32'h2004_0002},
    {1'b1, 2'd0, 1'b0, 32'h0000_0002},
    {1'b1, 2'd1, 1'b0, 32'h0000_0001},
    {1'b0, 2'd1, 1'b0, 32'h2000_0001},
    {1'b1, 2'd0, 1'b0, 32'h0000_0003},
    {1'b0, 2'd0, 1'b0, 32'h0000_0002},
    {1'b1, 2'd2, 1'b0, 32'hDEAD_BEEF},
    {1'b0, 2'd2, 1'b0, 32'hDEAD_BEEF},
    {1'b1, 2'd0, 1'b0, 32'h0000_0000},
    {1'b0, 2'd1, 1'b0, 32'h2000_0045},
    {1'b1, 2'd1, 1'b0, 32'hFFFF_FFFF},
    {1'b0, 2'd1, 1'b0, 32'h280B_FFFF},
    {1'b1, 2'd1, 1'b0, 32'h0000_0000},
    {1'b0, 2'd1, 1'b0, 32'h280B_FFFF},
    {1'b1, 2'd2, 1'b0, 32'h0000_1234},
    {1'b0, 2'd2, 1'b0, 32'h0000_0000},
    {1'b1, 2'd1, 1'b1, 32'h0000_0002},
    {1'b0, 2'd1, 1'b0, 32'h2000_0002},
    {1'b1, 2'd0, 1'b0, 32'hFFFF_FFF0},
    {1'b0, 2'd0, 1'b0, 32'h0000_0000}
  };
  localparam string VREQ [NV] = '{
    "R7", "R4", "R3", "R3", "R1", "R3", "R3", "R1", "R10", "R10",
    "R1", "R1", "R10", "R10", "R1", "R10", "R8", "R9", "R2", "R2",
    "R2", "R2", "R2", "R2", "R1", "R1"
  };

  task automatic check(input string req, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [XLEN-1:0] d,
                          input logic dbg);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; dbg_active = dbg;
    @(negedge clk);
    wr_en = 1'b0; dbg_active = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [XLEN-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  initial begin
    logic [XLEN-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    do_read(2'd0, v); check("R7 select", v, 32'h0);
    do_read(2'd2, v); check("R7 value", v, 32'h0);
    check("R7 flags", {29'd0, chk_fetch, chk_load, chk_store}, 32'h0);
    check("R7 flush", {31'd0, xlate_flush}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        do_write(VEC[i][34:33], VEC[i][31:0], VEC[i][32]);
      end else begin
        do_read(VEC[i][34:33], v);
        check(VREQ[i], v, VEC[i][31:0]);
      end
    end

    // R5: trig0 store, trig1 store, trig2 load
    check("R5 flags", {29'd0, chk_fetch, chk_load, chk_store}, 32'h3);
    do_write(2'd0, 32'd2, 1'b0);
    do_write(2'd1, 32'h0000_0004, 1'b0);
    // R6: accepted control write pulses flush for one cycle
    check("R6 flush high", {31'd0, xlate_flush}, 32'h1);
    check("R5 flags after exec", {29'd0, chk_fetch, chk_load, chk_store}, 32'h5);
    @(negedge clk);
    check("R6 flush one cycle", {31'd0, xlate_flush}, 32'h0);

    // R6: refused write gives no flush; value write gives no flush
    do_write(2'd1, 32'h0800_0000, 1'b0);
    do_write(2'd1, 32'h0000_0000, 1'b0);
    check("R6 refused no flush", {31'd0, xlate_flush}, 32'h0);
    do_read(2'd1, v); check("R2 locked kept", v, 32'h2800_0000);
    do_write(2'd2, 32'h55, 1'b1);
    check("R6 value no flush", {31'd0, xlate_flush}, 32'h0);
    do_read(2'd2, v); check("R2 dbg value write", v, 32'h55);
    check("R5 flags after lock", {29'd0, chk_fetch, chk_load, chk_store}, 32'h1);

    // R7: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(2'd1, v); check("R7 ctl after reset", v, 32'h2000_0000);
    check("R7 flags after reset", {29'd0, chk_fetch, chk_load, chk_store}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule